// File: doc/BRIEF.md
# Gated Output Port with Per-Pin Change Strobes

This block is a byte-addressed general-purpose output port. Software writes a 24-bit level register and a 24-bit drive-enable register, one byte at a time. Each pin carries the AND of its level bit and its enable bit, so a pin that is not enabled sits low.

The block holds the last level it drove. When a write moves the gated value, it updates only the pins whose gated level differs and raises a change strobe on each of those pins for one cycle. A write that leaves the gated value as it was changes nothing and fires no strobe, even when it changes a stored byte. Only the lowest sixteen pins have a strobe. Pins above that still follow their gated level but give no notification.

Reads return the stored register bytes through a combinational path. Addresses outside the six register bytes read as zero and ignore writes.

Top module: `gpio_out_notify`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pins`, `strobe` and every register byte read back are zero.
- R2: Level bytes sit at addresses 0x78, 0x79 and 0x7A and hold pin bits 7:0, 15:8 and 23:16 in that order. A read of each returns the stored byte.
- R3: Enable bytes sit at addresses 0x7C, 0x7D and 0x7E with the same byte-to-bit mapping as the level bytes. A read of each returns the stored byte.
- R4: From the clock edge that accepts a write, each pin shows its level bit ANDed with its enable bit.
- R5: A strobe bit is high for exactly the one cycle after the write that flipped that pin's gated level. Otherwise it is low.
- R6: A write that leaves every gated level unchanged, such as new level bits on disabled pins, fires no strobe and leaves `pins` unchanged.
- R7: Strobes exist only for pins 0 to 15. Pins 16 to 23 follow their gated level with no strobe.
- R8: A write to any other address changes neither `pins` nor `strobe`, and a read of any other address returns 0x00.
- R9: A read addressed to a byte in the same cycle that writes it returns the value stored before that clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Combinational read byte at `addr` |
| pins | output | 24 | Gated output levels |
| strobe | output | 16 | One-cycle change pulses for pins 0 to 15 |

## Verification
In a single cycle the block can both return a read of a byte and latch a write to that same byte, and the same write can also raise change strobes. The bench provokes this by holding the address on a level byte while writing a value that drops enabled pins. It samples `rdata` before the edge and expects the old byte. After the edge it expects the new pin levels and the strobe pattern. Random writes over the mapped bytes and two unmapped addresses put strobe pulses in back-to-back cycles, and a behavioural model judges every cycle.

// File: rtl/gpio_out_notify.sv
module gpio_out_notify #(
  parameter int ADDR_W       = 8,
  parameter int LANES        = 3,
  parameter int NOTIFY_LINES = 16,
  parameter int DATA_BASE    = 'h78,
  parameter int OE_BASE      = 'h7C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic [8*LANES-1:0]      pins,
  output logic [NOTIFY_LINES-1:0] strobe
);
  localparam int W = 8 * LANES;

  logic [W-1:0] dat_q, oe_q, lvl_q;
  logic [W-1:0] dat_d, oe_d;
  logic [NOTIFY_LINES-1:0] stb_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire hit_dat = wr_en && (addr == ADDR_W'(DATA_BASE + g));
    wire hit_oe  = wr_en && (addr == ADDR_W'(OE_BASE + g));
    assign dat_d[8*g +: 8] = hit_dat ? wdata : dat_q[8*g +: 8];
    assign oe_d[8*g +: 8]  = hit_oe  ? wdata : oe_q[8*g +: 8];
  end

  wire [W-1:0] eff_d = dat_d & oe_d;
  wire [W-1:0] diff  = eff_d ^ lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      oe_q  <= '0;
      lvl_q <= '0;
      stb_q <= '0;
    end else begin
      dat_q <= dat_d;
      oe_q  <= oe_d;
      lvl_q <= lvl_q ^ diff;
      stb_q <= diff[NOTIFY_LINES-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (addr == ADDR_W'(DATA_BASE + i)) rdata = dat_q[8*i +: 8];
      if (addr == ADDR_W'(OE_BASE + i))   rdata = oe_q[8*i +: 8];
    end
  end

  assign pins   = lvl_q;
  assign strobe = stb_q;
endmodule

// File: rtl/gpio_out_notify_chk.sv
module gpio_out_notify_chk #(
  parameter int ADDR_W       = 8,
  parameter int LANES        = 3,
  parameter int NOTIFY_LINES = 16,
  parameter int DATA_BASE    = 'h78,
  parameter int OE_BASE      = 'h7C
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [7:0]              wdata,
  input logic [7:0]              rdata,
  input logic [8*LANES-1:0]      pins,
  input logic [NOTIFY_LINES-1:0] strobe
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (addr == ADDR_W'(DATA_BASE + i) || addr == ADDR_W'(OE_BASE + i)) mapped = 1'b1;
  end

  wire [NOTIFY_LINES-1:0] low_pins = pins[NOTIFY_LINES-1:0];

  AST_STROBE_MATCHES_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe == (low_pins ^ $past(low_pins))); // R5

  AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (strobe == '0) && $stable(pins)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rdata == 8'h00); // R8

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped) |=> (strobe == '0) && $stable(pins)); // R8
endmodule

bind gpio_out_notify gpio_out_notify_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .NOTIFY_LINES(NOTIFY_LINES),
  .DATA_BASE(DATA_BASE), .OE_BASE(OE_BASE)
) u_chk (.*);

// File: tb/gpio_out_notify_bench.sv
`timescale 1ns/1ps
module gpio_out_notify_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [23:0] pins;
  logic [15:0] strobe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_out_notify u_gpio_out_notify (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins(pins), .strobe(strobe));

  bit [23:0] m_dat, m_oe, m_lvl;
  bit [15:0] m_stb;

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'h78: return m_dat[7:0];
      8'h79: return m_dat[15:8];
      8'h7A: return m_dat[23:16];
      8'h7C: return m_oe[7:0];
      8'h7D: return m_oe[15:8];
      8'h7E: return m_oe[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit [23:0] old;
    bit [23:0] flip;
    if (!rst_n) begin
      m_dat = '0; m_oe = '0; m_lvl = '0; m_stb = '0;
    end else begin
      old = m_lvl;
      if (wr_en) begin
        case (addr)
          8'h78: m_dat[7:0]   = wdata;
          8'h79: m_dat[15:8]  = wdata;
          8'h7A: m_dat[23:16] = wdata;
          8'h7C: m_oe[7:0]    = wdata;
          8'h7D: m_oe[15:8]   = wdata;
          8'h7E: m_oe[23:16]  = wdata;
          default: ;
        endcase
      end
      m_lvl = m_dat & m_oe;
      flip  = m_lvl ^ old;
      m_stb = flip[15:0];
    end
    #5;
    if (rst_n && !done) begin
      chk(pins == m_lvl, "R4 model pins", pins, m_lvl);
      chk(strobe == m_stb, "R5 model strobe", strobe, m_stb);
      chk(rdata == m_read(addr), "R2/R3 model rdata", rdata, m_read(addr));
    end
  end

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input bit [7:0] a, input bit [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1 chk(rdata == exp, req, rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(pins == 24'h0, "R1 pins in reset", pins, 0);
    chk(strobe == 16'h0, "R1 strobe in reset", strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pins == 24'h0 && strobe == 16'h0, "R1 after reset", {strobe, pins}, 0);
    rd_chk(8'h7C, 8'h00, "R1 enable readback zero");

    wr(8'h78, 8'hA5);
    chk(pins == 24'h0, "R6 level write on disabled pins", pins, 0);
    chk(strobe == 16'h0, "R6 no strobe", strobe, 0);
    rd_chk(8'h78, 8'hA5, "R2 level byte 0 readback");

    wr(8'h7C, 8'h0F);
    chk(pins == 24'h000005, "R4 gated pins", pins, 24'h000005);
    chk(strobe == 16'h0005, "R5 strobe on enable", strobe, 16'h0005);
    @(negedge clk);
    chk(strobe == 16'h0000, "R5 strobe lasts one cycle", strobe, 0);

    wr(8'h7E, 8'hFF);
    wr(8'h7A, 8'h3C);
    chk(pins == 24'h3C0005, "R7 upper pins follow", pins, 24'h3C0005);
    chk(strobe == 16'h0000, "R7 no upper strobe", strobe, 0);
    rd_chk(8'h7E, 8'hFF, "R3 enable byte 2 readback");
    rd_chk(8'h7A, 8'h3C, "R2 level byte 2 readback");

    wr(8'h79, 8'hFF);
    chk(pins == 24'h3C0005 && strobe == 16'h0, "R6 disabled middle byte", pins, 24'h3C0005);
    wr(8'h7D, 8'h81);
    chk(pins == 24'h3C8105, "R4 middle byte gated", pins, 24'h3C8105);
    chk(strobe == 16'h8100, "R5 middle strobe", strobe, 16'h8100);
    rd_chk(8'h7D, 8'h81, "R3 enable byte 1 readback");

    wr(8'h7B, 8'hFF);
    chk(pins == 24'h3C8105 && strobe == 16'h0, "R8 unmapped write inert", pins, 24'h3C8105);
    rd_chk(8'h7B, 8'h00, "R8 unmapped read zero");
    rd_chk(8'h80, 8'h00, "R8 unmapped read zero high");

    @(negedge clk);
    wr_en = 1'b1; addr = 8'h78; wdata = 8'h00;
    #1 chk(rdata == 8'hA5, "R9 read during write returns old", rdata, 8'hA5);
    @(negedge clk);
    wr_en = 1'b0;
    chk(pins == 24'h3C8100, "R9 write lands", pins, 24'h3C8100);
    chk(strobe == 16'h0005, "R5 falling strobe", strobe, 16'h0005);
    chk(rdata == 8'h00, "R9 new value after edge", rdata, 0);

    for (int n = 0; n < 400; n++) begin
      bit [7:0] a;
      case ($urandom_range(0, 7))
        0: a = 8'h78; 1: a = 8'h79; 2: a = 8'h7A; 3: a = 8'h7C;
        4: a = 8'h7D; 5: a = 8'h7E; 6: a = 8'h7B; default: a = 8'h90;
      endcase
      @(negedge clk);
      wr_en = ($urandom_range(0, 3) != 0);
      addr = a;
      wdata = 8'($urandom);
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule